// File: doc/BRIEF.md
# Evaluation Stack State Save/Restore Engine

This block copies the contents of a small register-file evaluation stack out to a state vector in word memory, and later copies it back. A save writes every live stack entry and always the two entries just above the top. It then writes one status word that packs the pending break byte with the stack pointer, and clears both. A restore reads that status word first. It reloads the break byte and the stack pointer from it, fetches the two link words kept beside it, and reloads the same span of stack entries.

The block is driven by a one-cycle `start` pulse, an operation select and a vector base address. It drives a word memory port whose read data returns one cycle after the request. It reaches the stack file through one index with a combinational read and a write strobe. The stack pointer and break byte are owned elsewhere: the block reads them on `start` and rewrites them through one strobe.

Top module: `stack_state_mover`

## Requirements
- R1: A save with stack pointer SP not above DEPTH writes vector words base+0 to base+SP+1 in ascending order, one per cycle, starting the cycle after `start`. Word base+k receives stack entry k+1.
- R2: Right after the stack words, a save writes the status word at base+DEPTH. Bits [15:8] hold the break byte, bits [7:0] hold SP, and the bits above are zero. The status write comes after any stack word written to the same address.
- R3: In the status-write cycle of a save, `ctl_we` pulses with `new_sp` = 0 and `new_brk` = 0.
- R4: A save with SP greater than DEPTH raises `err` for one cycle, in the cycle after `start`. It makes no memory access, no stack write, no `ctl_we` and no `done`.
- R5: A restore first reads base+DEPTH. In the next cycle it pulses `ctl_we` with `new_brk` = status[15:8] and `new_sp` = status[7:0].
- R6: A restore writes stack entries 1 to SP+2 in ascending order, one per cycle. Entry k+1 receives vector word base+k, with SP taken from the restored status word.
- R7: A restore reads base+DEPTH+1 onto `src_link` and base+DEPTH+2 onto `dst_link`. Both hold their values until the next successful restore.
- R8: `done` is a one-cycle pulse, in the cycle after the last memory or stack write of a successful operation.
- R9: A `start` that arrives while `busy` is high is ignored.
- R10: A restore whose status low byte is greater than DEPTH pulses `err` two cycles after its status read. It makes no stack write, no `ctl_we`, no `done`, and leaves both links unchanged.
- R11: `busy` is high from the cycle after an accepted `start` through the `done` cycle. While `busy` is low, the block makes no memory access, no stack write and no `ctl_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command pulse |
| op_restore | input | 1 | 0 = save, 1 = restore |
| base | input | AW | State vector base address |
| cur_sp | input | 8 | Current stack pointer, read on save |
| cur_brk | input | 8 | Current break byte, read on save |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |
| err | output | 1 | Stack error pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | W | Memory write data |
| mem_rdata | input | W | Read data, valid the cycle after a read request |
| stk_idx | output | IW | Stack file entry index |
| stk_we | output | 1 | Stack file write strobe |
| stk_wdata | output | W | Stack file write data |
| stk_rdata | input | W | Stack file read data at `stk_idx` (combinational) |
| ctl_we | output | 1 | Write strobe for stack pointer and break byte |
| new_sp | output | 8 | Stack pointer value to write |
| new_brk | output | 8 | Break byte value to write |
| src_link | output | W | Source link from the last restore |
| dst_link | output | W | Destination link from the last restore |

## Verification
The assertions assume that `mem_rdata` returns the addressed word exactly one cycle after a read request, and that `stk_rdata` reflects `stk_idx` within the same cycle. The bench's memory and stack models are built to meet both conditions. The stimulus keeps the vectors of different commands far enough apart that the two-word overshoot never reaches another test's vector. It also drives an invalid stack pointer only through the save command or through a deliberately corrupted status word.

// File: rtl/stack_state_mover.sv
module stack_state_mover #(
  parameter int D  = 14,
  parameter int W  = 16,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_restore,
  input  logic [AW-1:0] base,
  input  logic [7:0]    cur_sp,
  input  logic [7:0]    cur_brk,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [W-1:0]  mem_wdata,
  input  logic [W-1:0]  mem_rdata,
  output logic [$clog2(D+3)-1:0] stk_idx,
  output logic          stk_we,
  output logic [W-1:0]  stk_wdata,
  input  logic [W-1:0]  stk_rdata,
  output logic          ctl_we,
  output logic [7:0]    new_sp,
  output logic [7:0]    new_brk,
  output logic [W-1:0]  src_link,
  output logic [W-1:0]  dst_link
);
  localparam int IW = $clog2(D+3);
  localparam logic [7:0] DEPTH8 = 8'(D);

  typedef enum logic [3:0] {
    S_IDLE, S_SV_STK, S_SV_STAT, S_RS_STAT, S_RS_CHK, S_RS_DST, S_RS_LD, S_RS_TAIL, S_FIN
  } st_t;

  st_t           st;
  logic [AW-1:0] base_q;
  logic [IW-1:0] cnt, sp_q;
  logic [7:0]    brk_q;
  logic          err_q;
  logic [W-1:0]  src_q, dst_q;
  logic          rd_ok, last;

  assign rd_ok = mem_rdata[7:0] <= DEPTH8;
  assign last  = cnt == sp_q + IW'(1);

  assign busy     = st != S_IDLE;
  assign done     = st == S_FIN;
  assign err      = err_q;
  assign src_link = src_q;
  assign dst_link = dst_q;

  assign mem_we  = (st == S_SV_STK) || (st == S_SV_STAT);
  assign mem_req = mem_we || (st == S_RS_STAT) || (st == S_RS_DST) || (st == S_RS_LD) ||
                   ((st == S_RS_CHK) && rd_ok);

  always_comb begin
    case (st)
      S_SV_STAT, S_RS_STAT: mem_addr = base_q + AW'(D);
      S_RS_CHK:             mem_addr = base_q + AW'(D + 1);
      S_RS_DST:             mem_addr = base_q + AW'(D + 2);
      default:              mem_addr = base_q + AW'(cnt);
    endcase
  end

  assign mem_wdata = (st == S_SV_STAT) ? W'({brk_q, 8'(sp_q)}) : stk_rdata;

  assign stk_idx   = (st == S_SV_STK) ? cnt + IW'(1) : cnt;
  assign stk_we    = ((st == S_RS_LD) && (cnt != '0)) || (st == S_RS_TAIL);
  assign stk_wdata = mem_rdata;

  assign ctl_we  = (st == S_SV_STAT) || ((st == S_RS_CHK) && rd_ok);
  assign new_sp  = (st == S_SV_STAT) ? 8'd0 : mem_rdata[7:0];
  assign new_brk = (st == S_SV_STAT) ? 8'd0 : mem_rdata[15:8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      base_q <= '0;
      cnt    <= '0;
      sp_q   <= '0;
      brk_q  <= '0;
      err_q  <= 1'b0;
      src_q  <= '0;
      dst_q  <= '0;
    end else begin
      err_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          base_q <= base;
          cnt    <= '0;
          if (op_restore) st <= S_RS_STAT;
          else if (cur_sp > DEPTH8) err_q <= 1'b1;
          else begin
            sp_q  <= IW'(cur_sp);
            brk_q <= cur_brk;
            st    <= S_SV_STK;
          end
        end
        S_SV_STK: begin
          cnt <= cnt + IW'(1);
          if (last) st <= S_SV_STAT;
        end
        S_SV_STAT: st <= S_FIN;
        S_RS_STAT: st <= S_RS_CHK;
        S_RS_CHK: if (rd_ok) begin
          sp_q <= IW'(mem_rdata[7:0]);
          st   <= S_RS_DST;
        end else begin
          err_q <= 1'b1;
          st    <= S_IDLE;
        end
        S_RS_DST: begin
          src_q <= mem_rdata;
          cnt   <= '0;
          st    <= S_RS_LD;
        end
        S_RS_LD: begin
          if (cnt == '0) dst_q <= mem_rdata;
          cnt <= cnt + IW'(1);
          if (last) st <= S_RS_TAIL;
        end
        S_RS_TAIL: st <= S_FIN;
        default:   st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stack_state_mover_chk.sv
module stack_state_mover_chk #(
  parameter int D = 14,
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic          mem_req,
  input logic          mem_we,
  input logic          stk_we,
  input logic [IW-1:0] stk_idx,
  input logic          ctl_we,
  input logic [7:0]    new_sp,
  input logic [7:0]    new_brk
);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_err_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !stk_we && !ctl_we));

  assert_err_alone_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && !done));

  assert_save_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && mem_we) |-> (new_sp == 8'd0 && new_brk == 8'd0));

  assert_stk_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stk_we |-> (stk_idx != '0 && int'(stk_idx) <= D + 2));

  assert_restored_sp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !mem_we) |-> (int'(new_sp) <= D));
endmodule

bind stack_state_mover stack_state_mover_chk #(.D(D), .IW($clog2(D+3))) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
  .mem_req(mem_req), .mem_we(mem_we), .stk_we(stk_we), .stk_idx(stk_idx),
  .ctl_we(ctl_we), .new_sp(new_sp), .new_brk(new_brk)
);

// File: tb/sim_stack_state_mover.sv
module sim_stack_state_mover;
  localparam int D = 14;
  localparam int W = 16;
  localparam int AW = 16;
  localparam int IW = $clog2(D+3);

  logic clk = 0, rst_n = 0, start = 0, op_restore = 0;
  logic [AW-1:0] base = '0;
  logic [7:0] cur_sp = '0, cur_brk = '0;
  logic busy, done, err, mem_req, mem_we, stk_we, ctl_we;
  logic [AW-1:0] mem_addr;
  logic [W-1:0] mem_wdata, mem_rdata, stk_wdata, stk_rdata, src_link, dst_link;
  logic [IW-1:0] stk_idx;
  logic [7:0] new_sp, new_brk;

  always #2 clk = ~clk;

  stack_state_mover #(.D(D), .W(W), .AW(AW)) u0 (.*);

  logic [15:0] mem_m [0:1023];
  logic [15:0] stk_m [0:D+2];
  assign stk_rdata = stk_m[int'(stk_idx)];
  always @(posedge clk) begin
    if (mem_req && mem_we) mem_m[mem_addr[9:0]] <= mem_wdata;
    if (mem_req && !mem_we) mem_rdata <= mem_m[mem_addr[9:0]];
    if (stk_we) stk_m[int'(stk_idx)] <= stk_wdata;
  end

  typedef struct {
    bit busy, req, we, swe, cwe, done, err;
    int addr, wdata, sidx, swd, nsp, nbrk;
    string tag;
  } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0;

  function automatic exp_t idle(string t);
    exp_t e;
    e = '{default: 0, tag: t};
    return e;
  endfunction

  always @(negedge clk) if (rst_n) begin
    exp_t e;
    bit bad;
    e = q.size() ? q.pop_front() : idle("R11");
    bad = (busy != e.busy) || (mem_req != e.req) || (done != e.done) || (err != e.err) ||
          (stk_we != e.swe) || (ctl_we != e.cwe);
    if (e.req && (mem_we != e.we || int'(mem_addr) != e.addr)) bad = 1;
    if (e.req && e.we && int'(mem_wdata) != e.wdata) bad = 1;
    if (e.swe && (int'(stk_idx) != e.sidx || int'(stk_wdata) != e.swd)) bad = 1;
    if (e.cwe && (int'(new_sp) != e.nsp || int'(new_brk) != e.nbrk)) bad = 1;
    checks++;
    if (bad) begin
      errors++;
      $display("FAIL %s t=%0t actual busy%0d req%0d we%0d a%h d%h swe%0d i%0d sd%h cwe%0d sp%0d bk%h done%0d err%0d expected busy%0d req%0d we%0d a%h d%h swe%0d i%0d sd%h cwe%0d sp%0d bk%h done%0d err%0d",
        e.tag, $time, busy, mem_req, mem_we, mem_addr, mem_wdata, stk_we, stk_idx, stk_wdata,
        ctl_we, new_sp, new_brk, done, err,
        e.busy, e.req, e.we, e.addr[15:0], e.wdata[15:0], e.swe, e.sidx, e.swd[15:0],
        e.cwe, e.nsp, e.nbrk[7:0], e.done, e.err);
    end
  end

  task automatic check(string tag, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic push_save(int b, int sp, int brk);
    exp_t e;
    if (sp > D) begin
      e = idle("R4"); e.err = 1; q.push_back(e);
      return;
    end
    for (int k = 0; k <= sp + 1; k++) begin
      e = idle("R1"); e.busy = 1; e.req = 1; e.we = 1; e.addr = b + k; e.wdata = stk_m[k+1];
      q.push_back(e);
    end
    e = idle("R2"); e.busy = 1; e.req = 1; e.we = 1; e.addr = b + D; e.wdata = (brk << 8) | sp;
    e.cwe = 1; e.nsp = 0; e.nbrk = 0; q.push_back(e);
    e = idle("R8"); e.busy = 1; e.done = 1; q.push_back(e);
  endtask

  task automatic push_restore(int b);
    exp_t e;
    int s, sp;
    s = mem_m[b + D];
    sp = s & 255;
    e = idle("R5"); e.busy = 1; e.req = 1; e.addr = b + D; q.push_back(e);
    if (sp > D) begin
      e = idle("R10"); e.busy = 1; q.push_back(e);
      e = idle("R10"); e.err = 1; q.push_back(e);
      return;
    end
    e = idle("R5"); e.busy = 1; e.req = 1; e.addr = b + D + 1; e.cwe = 1; e.nsp = sp; e.nbrk = s >> 8;
    q.push_back(e);
    e = idle("R7"); e.busy = 1; e.req = 1; e.addr = b + D + 2; q.push_back(e);
    for (int k = 0; k <= sp + 1; k++) begin
      e = idle("R6"); e.busy = 1; e.req = 1; e.addr = b + k;
      if (k > 0) begin e.swe = 1; e.sidx = k; e.swd = mem_m[b + k - 1]; end
      q.push_back(e);
    end
    e = idle("R6"); e.busy = 1; e.swe = 1; e.sidx = sp + 2; e.swd = mem_m[b + sp + 1]; q.push_back(e);
    e = idle("R8"); e.busy = 1; e.done = 1; q.push_back(e);
  endtask

  task automatic go(bit rs, int b, int sp, int brk);
    @(posedge clk); #1;
    start = 1; op_restore = rs; base = AW'(b); cur_sp = 8'(sp); cur_brk = 8'(brk);
    q.push_back(idle("R11"));
    if (rs) push_restore(b); else push_save(b, sp, brk);
    @(posedge clk); #1;
    start = 0;
  endtask

  task automatic settle();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic fill_stack(int seed);
    for (int i = 0; i <= D + 2; i++) stk_m[i] = 16'(seed + i * 16'h0101);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem_m[i] = 16'(i ^ 16'hA500);
    fill_stack(16'h1000);
    mem_m[256 + D + 1] = 16'h1111;
    mem_m[256 + D + 2] = 16'h2222;
    mem_m[384 + D + 2] = 16'h3333;
    mem_m[1024 - 64 + D] = 16'h0714;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check("R11 reset busy", busy, 0);
    check("R8 reset done", done, 0);
    check("R7 reset src", src_link, 0);
    check("R7 reset dst", dst_link, 0);

    go(0, 256, 3, 8'h5A); settle();
    check("R2 status stored", mem_m[256 + D], 16'h5A03);
    check("R1 word0", mem_m[256], stk_m[1]);

    fill_stack(16'h7000);
    go(1, 256, 0, 0); settle();
    check("R6 entry1", stk_m[1], mem_m[256]);
    check("R6 entry5", stk_m[5], mem_m[260]);
    check("R6 entry6 untouched", stk_m[6], 16'h7000 + 6 * 16'h0101);
    check("R7 src", src_link, 16'h1111);
    check("R7 dst", dst_link, 16'h2222);

    go(0, 320, 0, 8'h01); settle();
    check("R2 status sp0", mem_m[320 + D], 16'h0100);

    fill_stack(16'h3000);
    go(0, 384, D, 8'h33); settle();
    check("R2 status wins overshoot", mem_m[384 + D], (16'h33 << 8) | D);
    check("R2 word after status", mem_m[384 + D + 1], stk_m[D + 2]);

    fill_stack(16'h9000);
    go(1, 384, 0, 0); settle();
    check("R6 entry D+2", stk_m[D + 2], mem_m[384 + D + 1]);
    check("R7 src full", src_link, mem_m[384 + D + 1]);
    check("R7 dst full", dst_link, 16'h3333);

    go(0, 512, D + 1, 8'h44); settle();
    check("R4 no write", mem_m[512], 16'(512 ^ 16'hA500));

    go(1, 1024 - 64, 0, 0); settle();
    check("R10 src held", src_link, mem_m[384 + D + 1]);
    check("R10 stack held", stk_m[1], mem_m[384]);

    fill_stack(16'h5000);
    go(0, 640, 4, 8'h22);
    @(posedge clk); #1;
    start = 1; op_restore = 1; base = AW'(1024 - 64);
    @(posedge clk); #1;
    start = 0;
    settle();
    check("R9 save completed", mem_m[640 + D], 16'h2204);
    check("R9 stack intact", stk_m[1], 16'h5000 + 16'h0101);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule